// File: doc/BRIEF.md
# Four-Agent MESI Coherence Line Tracker

This block follows the coherence state of one cache line held by four processors that use write-back caches and a snooping MESI protocol. Each cycle it can accept one serialized request. A request names the processor that issues it and says whether it is a read or a write. The block then moves every cache's copy of the line to its new state.

It also tracks whether main memory holds an up-to-date copy or a stale one. For each request it reports the bus traffic the request causes. That traffic is a write-back from a dirty owner, naming that owner, and a line fill from memory into the requester's cache. On a write miss the block allocates the line, and a dirty owner flushes before the requester fills.

Everything is reported through registered outputs one cycle after the request. The block can drive a coherence scoreboard or a protocol model sitting beside a cache cluster. It carries no data, addresses or arbitration.

Top module: `mesi_line_tracker`

## Requirements
- R1: After reset every agent's state is Invalid, `mem_valid` is 1, and `wb_valid` and `fill_valid` are 0. State codes in `line_state`, two bits per agent with agent k at bits [2k+1:2k], are Invalid=0, Shared=1, Exclusive=2, Modified=3.
- R2: A read by an Invalid agent when no other agent holds the line makes the requester Exclusive. It reports a fill and no write-back, and `mem_valid` is left unchanged.
- R3: A write by an agent in Exclusive makes it Modified and clears `mem_valid`, with no fill and no write-back.
- R4: A read by an Invalid agent while another agent is Modified reports a write-back with `wb_id` equal to that owner, and also reports a fill. Both agents end in Shared, and `mem_valid` becomes 1.
- R5: A read by an Invalid agent while other agents hold only Shared copies makes the requester Shared. It reports a fill only, and the other copies stay Shared.
- R6: A read by an Invalid agent while another agent is Exclusive moves that agent to Shared and makes the requester Shared. It reports a fill and no write-back.
- R7: A write by an agent in Shared makes it Modified, sets every other agent to Invalid and clears `mem_valid`, with no fill and no write-back.
- R8: A write by an Invalid agent while another agent is Modified reports a write-back with `wb_id` equal to that owner, and also reports a fill. The owner goes to Invalid, the requester ends in Modified, and `mem_valid` is 0.
- R9: A write by an Invalid agent while no other agent is Modified reports a fill and no write-back. It invalidates every other copy, makes the requester Modified and clears `mem_valid`.
- R10: A read by an agent in Modified, Exclusive or Shared, and a write by an agent in Modified, change no state and report neither a fill nor a write-back.
- R11: In a cycle with `req_valid` low, the following cycle shows the states and `mem_valid` unchanged, with `wb_valid` and `fill_valid` both 0.
- R12: The effects of a request accepted at one rising edge appear on all outputs from that edge on, and a fill is only ever reported for a requester that was Invalid.
- R13: At most one agent is in Modified or Exclusive, and while one is, every other agent is Invalid. While `mem_valid` is 0, exactly one agent is Modified.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| req_id | input | 2 | Requesting agent, 0 to 3 |
| req_write | input | 1 | 1 for a write, 0 for a read |
| wb_valid | output | 1 | The previous request caused an owner write-back |
| wb_id | output | 2 | Agent that wrote the line back, meaningful when `wb_valid` is 1 |
| fill_valid | output | 1 | The previous request caused the requester to fill from memory |
| line_state | output | 8 | Per-agent MESI state, agent k at bits [2k+1:2k] |
| mem_valid | output | 1 | Main memory's copy of the line is up to date |

## Verification
The bench builds the tracker with its default of four agents. This is small enough to replay every possible sequence of three requests from reset, 512 sequences drawn from eight requester and operation pairs. Three steps are enough to reach every coherence state. That includes Modified owners met by read and write misses, Exclusive holders downgraded by another reader, and Shared groups upgraded by a writer, each issued by every agent against every other. An idle cycle after each request covers the hold behaviour, and a reference model in the bench derived from the requirements gives the expected states and bus events.

// File: rtl/mesi_tracker_pkg.sv
// Package: shared state encoding for the MESI line tracker.
// Assumes two bits per agent; the code values are visible on the top ports.
package mesi_tracker_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_t;
endpackage

// File: rtl/mesi_snoop_summary.sv
// Module: mesi_snoop_summary
// Condenses the states of every agent other than the requester into
// presence flags and the identity of a Modified owner.
// Assumes the coherence invariant holds, so at most one owner exists.
module mesi_snoop_summary
    import mesi_tracker_pkg::*;
#(
    parameter int N_AGENTS = 4,
    localparam int IDW = $clog2(N_AGENTS)
) (
    input  logic [2*N_AGENTS-1:0] cur_state,
    input  logic [IDW-1:0]        req_id,
    output line_st_t              req_state,
    output logic                  other_m,
    output logic                  other_e,
    output logic                  other_s,
    output logic [IDW-1:0]        owner_id
);
    logic [N_AGENTS-1:0] hit_m;
    logic [N_AGENTS-1:0] hit_e;
    logic [N_AGENTS-1:0] hit_s;

    // Per-agent snoop response, masked for the requester itself.
    for (genvar k = 0; k < N_AGENTS; k++) begin : g_snoop
        logic is_other;
        assign is_other = (req_id != IDW'(k));
        assign hit_m[k] = is_other && (line_st_t'(cur_state[2*k +: 2]) == ST_M);
        assign hit_e[k] = is_other && (line_st_t'(cur_state[2*k +: 2]) == ST_E);
        assign hit_s[k] = is_other && (line_st_t'(cur_state[2*k +: 2]) == ST_S);
    end

    assign other_m   = |hit_m;
    assign other_e   = |hit_e;
    assign other_s   = |hit_s;
    assign req_state = line_st_t'(cur_state[2*req_id +: 2]);

    // Encode the index of the Modified owner (zero when none).
    always_comb begin
        owner_id = '0;
        for (int k = 0; k < N_AGENTS; k++) begin
            if (hit_m[k]) owner_id = IDW'(k);
        end
    end
endmodule

// File: rtl/mesi_next_state.sv
// Module: mesi_next_state
// Pure combinational transition logic: from the snoop summary and the
// request kind it derives each agent's next state, memory validity and
// the bus events. Assumes one serialized request at a time.
module mesi_next_state
    import mesi_tracker_pkg::*;
#(
    parameter int N_AGENTS = 4,
    localparam int IDW = $clog2(N_AGENTS)
) (
    input  logic [2*N_AGENTS-1:0] cur_state,
    input  logic                  cur_mem_valid,
    input  logic [IDW-1:0]        req_id,
    input  logic                  req_write,
    input  line_st_t              req_state,
    input  logic                  other_m,
    input  logic                  other_e,
    input  logic                  other_s,
    output logic [2*N_AGENTS-1:0] nxt_state,
    output logic                  nxt_mem_valid,
    output logic                  do_wb,
    output logic                  do_fill
);
    logic     miss;
    logic     kill_others;
    logic     share_others;
    line_st_t req_next;

    assign miss         = (req_state == ST_I);
    assign do_fill      = miss;
    assign do_wb        = miss && other_m;
    assign kill_others  = req_write;
    assign share_others = !req_write && miss;

    // Requester's own next state.
    always_comb begin
        if (req_write)
            req_next = ST_M;
        else if (miss)
            req_next = (other_m || other_e || other_s) ? ST_S : ST_E;
        else
            req_next = req_state;
    end

    // Memory copy: any write leaves it stale, a flush on a read refreshes it.
    always_comb begin
        if (req_write)
            nxt_mem_valid = 1'b0;
        else if (do_wb)
            nxt_mem_valid = 1'b1;
        else
            nxt_mem_valid = cur_mem_valid;
    end

    // Per-agent next state for requester and snoopers.
    for (genvar k = 0; k < N_AGENTS; k++) begin : g_next
        line_st_t now_st;
        line_st_t new_st;
        assign now_st = line_st_t'(cur_state[2*k +: 2]);
        always_comb begin
            if (req_id == IDW'(k))
                new_st = req_next;
            else if (kill_others)
                new_st = ST_I;
            else if (share_others && (now_st == ST_M || now_st == ST_E))
                new_st = ST_S;
            else
                new_st = now_st;
        end
        assign nxt_state[2*k +: 2] = new_st;
    end
endmodule

// File: rtl/mesi_line_tracker.sv
// Module: mesi_line_tracker (top)
// Tracks MESI coherence of one line across N_AGENTS write-back caches and
// main memory. A request presented with req_valid is applied at the next
// rising edge; states and bus events are registered outputs.
// Assumes requests are serialized and req_id is below N_AGENTS.
module mesi_line_tracker
    import mesi_tracker_pkg::*;
#(
    parameter int N_AGENTS = 4,
    localparam int IDW = $clog2(N_AGENTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [IDW-1:0]        req_id,
    input  logic                  req_write,
    output logic                  wb_valid,
    output logic [IDW-1:0]        wb_id,
    output logic                  fill_valid,
    output logic [2*N_AGENTS-1:0] line_state,
    output logic                  mem_valid
);
    line_st_t              req_state;
    logic                  other_m;
    logic                  other_e;
    logic                  other_s;
    logic [IDW-1:0]        owner_id;
    logic [2*N_AGENTS-1:0] nxt_state;
    logic                  nxt_mem_valid;
    logic                  do_wb;
    logic                  do_fill;

    mesi_snoop_summary #(.N_AGENTS(N_AGENTS)) u_snoop (
        .cur_state (line_state),
        .req_id    (req_id),
        .req_state (req_state),
        .other_m   (other_m),
        .other_e   (other_e),
        .other_s   (other_s),
        .owner_id  (owner_id)
    );

    mesi_next_state #(.N_AGENTS(N_AGENTS)) u_next (
        .cur_state     (line_state),
        .cur_mem_valid (mem_valid),
        .req_id        (req_id),
        .req_write     (req_write),
        .req_state     (req_state),
        .other_m       (other_m),
        .other_e       (other_e),
        .other_s       (other_s),
        .nxt_state     (nxt_state),
        .nxt_mem_valid (nxt_mem_valid),
        .do_wb         (do_wb),
        .do_fill       (do_fill)
    );

    // Coherence state and memory validity registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_state <= '0;
            mem_valid  <= 1'b1;
        end else if (req_valid) begin
            line_state <= nxt_state;
            mem_valid  <= nxt_mem_valid;
        end
    end

    // Bus event report registers, pulsed for one cycle per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid   <= 1'b0;
            wb_id      <= '0;
            fill_valid <= 1'b0;
        end else begin
            wb_valid   <= req_valid && do_wb;
            wb_id      <= owner_id;
            fill_valid <= req_valid && do_fill;
        end
    end
endmodule

// File: rtl/mesi_line_tracker_chk.sv
// Module: mesi_line_tracker_chk
// Protocol checker bound to mesi_line_tracker; observes ports only.
module mesi_line_tracker_chk
#(
    parameter int N_AGENTS = 4,
    localparam int IDW = $clog2(N_AGENTS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic [IDW-1:0]        req_id,
    input logic                  req_write,
    input logic                  wb_valid,
    input logic [IDW-1:0]        wb_id,
    input logic                  fill_valid,
    input logic [2*N_AGENTS-1:0] line_state,
    input logic                  mem_valid
);
    int unsigned           cnt_me;
    int unsigned           cnt_m;
    int unsigned           cnt_live;
    logic                  q_valid;
    logic                  q_write;
    logic [IDW-1:0]        q_id;
    logic [1:0]            q_req_st;
    logic [2*N_AGENTS-1:0] q_state;

    // Count owners and live copies in the current state vector.
    always_comb begin
        cnt_me   = 0;
        cnt_m    = 0;
        cnt_live = 0;
        for (int k = 0; k < N_AGENTS; k++) begin
            if (line_state[2*k+1]) cnt_me++;
            if (line_state[2*k +: 2] == 2'd3) cnt_m++;
            if (line_state[2*k +: 2] != 2'd0) cnt_live++;
        end
    end

    // Remember last cycle's request and the states it saw.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid  <= 1'b0;
            q_write  <= 1'b0;
            q_id     <= '0;
            q_req_st <= 2'd0;
            q_state  <= '0;
        end else begin
            q_valid  <= req_valid;
            q_write  <= req_write;
            q_id     <= req_id;
            q_req_st <= line_state[2*req_id +: 2];
            q_state  <= line_state;
        end
    end

    assert_single_owner_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_me == 0) || (cnt_live == 1));

    assert_stale_has_owner_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_valid |-> (cnt_m == 1));

    assert_wb_with_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (fill_valid && wb_id != q_id));

    assert_fill_on_miss_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> (q_valid && q_req_st == 2'd0));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |-> (!wb_valid && !fill_valid && line_state == q_state));

    assert_write_owns_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && q_write) |-> (line_state[2*q_id +: 2] == 2'd3 && !mem_valid));
endmodule

bind mesi_line_tracker mesi_line_tracker_chk #(.N_AGENTS(N_AGENTS)) u_chk (.*);

// File: tb/mesi_line_tracker_test.sv
// Bench: replays every three-request sequence from reset against a
// requirement-level reference model.
module mesi_line_tracker_test;
    localparam int NA = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_id = '0;
    logic          req_write = 1'b0;
    logic          wb_valid;
    logic [1:0]    wb_id;
    logic          fill_valid;
    logic [2*NA-1:0] line_state;
    logic          mem_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_st[NA];
    int m_mem;
    int e_wb, e_wbid, e_fill;
    string e_tag;

    always #10 clk = ~clk;

    mesi_line_tracker #(.N_AGENTS(NA)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
        .req_write(req_write), .wb_valid(wb_valid), .wb_id(wb_id),
        .fill_valid(fill_valid), .line_state(line_state), .mem_valid(mem_valid)
    );

    function automatic logic [2*NA-1:0] model_vec();
        logic [2*NA-1:0] v;
        for (int k = 0; k < NA; k++) v[2*k +: 2] = 2'(m_st[k]);
        return v;
    endfunction

    // Reference model: codes I=0 S=1 E=2 M=3.
    task automatic model_step(input int id, input int wr);
        int rs = m_st[id];
        int om = -1;
        bit oe = 0, os = 0;
        for (int k = 0; k < NA; k++) if (k != id) begin
            if (m_st[k] == 3) om = k;
            if (m_st[k] == 2) oe = 1;
            if (m_st[k] == 1) os = 1;
        end
        e_wb = 0; e_wbid = 0; e_fill = 0;
        if (!wr) begin
            if (rs != 0) e_tag = "R10";
            else begin
                e_fill = 1;
                if (om >= 0) begin
                    e_wb = 1; e_wbid = om; m_st[om] = 1; m_st[id] = 1; m_mem = 1; e_tag = "R4";
                end else if (oe) begin
                    for (int k = 0; k < NA; k++) if (m_st[k] == 2) m_st[k] = 1;
                    m_st[id] = 1; e_tag = "R6";
                end else if (os) begin
                    m_st[id] = 1; e_tag = "R5";
                end else begin
                    m_st[id] = 2; e_tag = "R2";
                end
            end
        end else begin
            if (rs == 3) e_tag = "R10";
            else begin
                if (rs == 2) e_tag = "R3";
                else if (rs == 1) e_tag = "R7";
                else begin
                    e_fill = 1;
                    if (om >= 0) begin e_wb = 1; e_wbid = om; e_tag = "R8"; end
                    else e_tag = "R9";
                end
                for (int k = 0; k < NA; k++) m_st[k] = 0;
                m_st[id] = 3; m_mem = 0;
            end
        end
    endtask

    task automatic compare(input string tag);
        logic [2*NA-1:0] ev = model_vec();
        bit bad;
        checks++;
        bad = (line_state !== ev) || (mem_valid !== 1'(m_mem)) ||
              (wb_valid !== 1'(e_wb)) || (fill_valid !== 1'(e_fill)) ||
              (e_wb != 0 && wb_id !== 2'(e_wbid));
        if (bad) begin
            errors++;
            $display("FAIL %s: state=%h mem=%0b wb=%0b/%0d fill=%0b expected state=%h mem=%0d wb=%0d/%0d fill=%0d",
                     tag, line_state, mem_valid, wb_valid, wb_id, fill_valid,
                     ev, m_mem, e_wb, e_wbid, e_fill);
        end
    endtask

    // R13 exclusivity seen at the ports.
    task automatic check_owner_rule();
        int me = 0, live = 0;
        for (int k = 0; k < NA; k++) begin
            if (line_state[2*k+1]) me++;
            if (line_state[2*k +: 2] != 2'd0) live++;
        end
        checks++;
        if (me > 1 || (me == 1 && live != 1)) begin
            errors++;
            $display("FAIL R13: owners=%0d live=%0d expected owners<=1 and live=1 with an owner", me, live);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < NA; k++) m_st[k] = 0;
        m_mem = 1; e_wb = 0; e_fill = 0;
        compare("R1");
    endtask

    task automatic step(input int code);
        int id = code % NA;
        int wr = code / NA;
        req_valid = 1'b1; req_id = 2'(id); req_write = wr[0];
        model_step(id, wr);
        @(negedge clk);
        req_valid = 1'b0;
        compare({e_tag, "/R12"});
        check_owner_rule();
        @(negedge clk);
        e_wb = 0; e_fill = 0;
        compare("R11");
    endtask

    initial begin
        for (int a = 0; a < 2*NA; a++)
            for (int b = 0; b < 2*NA; b++)
                for (int c = 0; c < 2*NA; c++) begin
                    do_reset();
                    step(a);
                    step(b);
                    step(c);
                end
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule